// File: doc/BRIEF.md
# Buffered Serial Byte Readout with Data-Ready Flag

This block sits behind a tone demodulator that delivers an already demodulated 1200-baud asynchronous bit stream (idle mark = 1, one start bit of 0, eight data bits with the first bit on the wire being bit 0, one stop bit of 1). It removes the framing and keeps only the eight data bits. As soon as the last data bit has been sampled, the byte is copied into a one-word output shift register and an active-low ready flag is raised, which is meant to interrupt a host controller.

The host fetches the byte serially. It drives a read clock pin that is asynchronous to the system clock, and each rising edge of that pin puts the next stored bit on the data pin, in the order the bits arrived. The first read edge given while the ready flag is low releases the flag at once. Without a read edge the flag releases by itself after half a bit time. Once eight bits have been fetched, further read edges do nothing. Data arriving while the carrier-valid input is low is not captured.

Top module: `cid_byte_reader`

## Requirements
- R1: After synchronous reset the ready flag `dr_n` is 1 and the data pin `data` is 1.
- R2: Only the eight data bits of a frame are stored. The start and stop bits never appear on `data`.
- R3: `dr_n` goes low only because a new byte was captured. It falls during the last data bit of the frame, between 8 and 9 bit times after the start bit's falling edge.
- R4: The n-th accepted rising edge of `dclk` (n = 1..8) puts the n-th received data bit on `data`, so bit 0 comes first. Between accepted edges `data` holds its value.
- R5: With no `dclk` edge, `dr_n` stays low for exactly `BIT_CLKS/2` system clock cycles after a capture.
- R6: A `dclk` rising edge that arrives while `dr_n` is low returns `dr_n` to 1 before the half-bit timeout would have.
- R7: After the eighth bit has been read, further `dclk` rising edges leave `data` unchanged.
- R8: While `carrier_ok` is 0 no frame is captured: `dr_n` stays 1 and the stored byte is not replaced. A partial read continues with the old byte.
- R9: A new byte captured before the host has finished reading replaces the buffer and restarts the read from bit 0.
- R10: A low pulse on `rx_bit` shorter than half a bit time is not taken as a start bit and produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Demodulated serial bit stream, 1 = mark, 0 = space |
| carrier_ok | input | 1 | High while a valid carrier is present. Capture is only allowed while it is high |
| dclk | input | 1 | Host read clock, asynchronous to `clk`, one bit per rising edge |
| data | output | 1 | Serial data out toward the host |
| dr_n | output | 1 | Data-ready flag, active low, driven high when idle |

## Verification
On every cycle the assertions check the following:
- the ready flag falls exactly one cycle after a capture and never without one;
- a capture only happens after carrier-valid was high;
- the flag never stays low longer than half a bit;
- a read edge clears a low flag on the next cycle;
- `data` moves only on an accepted read edge, and never after eight edges since the last capture.

Only the bench scenarios can show the rest. That covers whether the byte that comes out matches what was framed on the line, in arrival order, and where in the frame the flag falls. It also covers that carrier loss preserves a half-read buffer, that a late word restarts the read at bit 0, and that short glitches are rejected.

// File: rtl/cid_rdo_pkg.sv
package cid_rdo_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/cid_rdo_deframer.sv
// Finds the start bit, samples each data bit at mid-bit and reports a full word.
module cid_rdo_deframer
  import cid_rdo_pkg::*;
#(
  parameter int BIT_CLKS  = 2983,
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_i,
  input  logic                 carrier_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 load_o
);
  localparam int CW = $clog2(BIT_CLKS + 1);
  localparam int IW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] FULL_M1 = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(BIT_CLKS / 2 - 1);
  localparam logic [IW-1:0] LAST_IX = IW'(WORD_BITS - 1);

  rx_state_e            state;
  logic                 rx_prev;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [WORD_BITS-1:0] shreg;

  assign word_o = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      rx_prev <= 1'b1;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o  <= 1'b0;
      rx_prev <= rx_i;
      if (!carrier_i) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: begin
            if (rx_prev && !rx_i) begin
              state <= RX_START;
              cnt   <= HALF_M1;
            end
          end
          RX_START: begin
            if (cnt == '0) begin
              if (!rx_i) begin
                state <= RX_DATA;
                cnt   <= FULL_M1;
                idx   <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == '0) begin
              shreg <= {rx_i, shreg[WORD_BITS-1:1]};
              if (idx == LAST_IX) begin
                load_o <= 1'b1;
                state  <= RX_IDLE;
              end else begin
                idx <= idx + 1'b1;
                cnt <= FULL_M1;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cid_rdo_edge_sync.sv
// Multi-flop synchronizer for the host read clock with registered rising-edge pulse.
module cid_rdo_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sq;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq     <= '0;
      prev   <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sq     <= {sq[STAGES-2:0], async_i};
      prev   <= sq[STAGES-1];
      rise_o <= sq[STAGES-1] & ~prev;
    end
  end
endmodule

// File: rtl/cid_rdo_outreg.sv
// One-word output buffer: serial readout, read counter, ready flag with timeout.
module cid_rdo_outreg #(
  parameter int WORD_BITS = 8,
  parameter int HALF_CLKS = 1491
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic                 rise_i,
  output logic                 data_o,
  output logic                 dr_n_o
);
  localparam int IW = $clog2(WORD_BITS + 1);
  localparam int TW = $clog2(HALF_CLKS + 1);
  localparam logic [IW-1:0] DONE    = IW'(WORD_BITS);
  localparam logic [TW-1:0] TMR_TOP = TW'(HALF_CLKS - 1);

  logic [WORD_BITS-1:0] sreg;
  logic [IW-1:0]        rd_cnt;
  logic [TW-1:0]        tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      rd_cnt <= DONE;
      tmr    <= '0;
      data_o <= 1'b1;
      dr_n_o <= 1'b1;
    end else if (load_i) begin
      sreg   <= word_i;
      rd_cnt <= '0;
      tmr    <= TMR_TOP;
      dr_n_o <= 1'b0;
    end else begin
      if (rise_i && (rd_cnt != DONE)) begin
        data_o <= sreg[0];
        sreg   <= {1'b0, sreg[WORD_BITS-1:1]};
        rd_cnt <= rd_cnt + 1'b1;
      end
      if (!dr_n_o) begin
        if (rise_i || (tmr == '0)) begin
          dr_n_o <= 1'b1;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cid_byte_reader.sv
module cid_byte_reader #(
  parameter int BIT_CLKS    = 2983,
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic carrier_ok,
  input  logic dclk,
  output logic data,
  output logic dr_n
);
  localparam int HALF_CLKS = BIT_CLKS / 2;

  logic [WORD_BITS-1:0] frm_word;
  logic                 frm_load;
  logic                 dclk_rise;

  cid_rdo_deframer #(
    .BIT_CLKS (BIT_CLKS),
    .WORD_BITS(WORD_BITS)
  ) u_dfr (
    .clk      (clk),
    .rst      (rst),
    .rx_i     (rx_bit),
    .carrier_i(carrier_ok),
    .word_o   (frm_word),
    .load_o   (frm_load)
  );

  cid_rdo_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(dclk),
    .rise_o (dclk_rise)
  );

  cid_rdo_outreg #(
    .WORD_BITS(WORD_BITS),
    .HALF_CLKS(HALF_CLKS)
  ) u_out (
    .clk   (clk),
    .rst   (rst),
    .load_i(frm_load),
    .word_i(frm_word),
    .rise_i(dclk_rise),
    .data_o(data),
    .dr_n_o(dr_n)
  );
endmodule

// File: rtl/cid_byte_reader_chk.sv
module cid_byte_reader_chk #(
  parameter int WORD_BITS = 8,
  parameter int HALF_CLKS = 1491
) (
  input logic clk,
  input logic rst,
  input logic dr_n,
  input logic data,
  input logic carrier_ok,
  input logic load,
  input logic rise
);
  int unsigned low_cnt;
  int unsigned edge_cnt;

  always_ff @(posedge clk) begin
    if (rst || dr_n || load) low_cnt <= 0;
    else                     low_cnt <= low_cnt + 1;
    if (rst)                 edge_cnt <= WORD_BITS;
    else if (load)           edge_cnt <= 0;
    else if (rise && edge_cnt < WORD_BITS) edge_cnt <= edge_cnt + 1;
  end

  assert_dr_falls_on_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> !dr_n);
  assert_dr_fall_has_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dr_n) |-> $past(load));
  assert_load_needs_carrier_R8: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(carrier_ok));
  assert_dr_low_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= HALF_CLKS);
  assert_edge_clears_dr_R6: assert property (@(posedge clk) disable iff (rst)
    (!dr_n && rise && !load) |=> dr_n);
  assert_data_holds_R4: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(data));
  assert_extra_edges_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (rise && !load && edge_cnt >= WORD_BITS) |=> $stable(data));
endmodule

bind cid_byte_reader cid_byte_reader_chk #(
  .WORD_BITS(WORD_BITS),
  .HALF_CLKS(HALF_CLKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dr_n      (dr_n),
  .data      (data),
  .carrier_ok(carrier_ok),
  .load      (frm_load),
  .rise      (dclk_rise)
);

// File: tb/cid_byte_reader_test.sv
`timescale 1ns/1ps
module cid_byte_reader_test;
  localparam int BIT  = 40;
  localparam int HALF = BIT / 2;
  localparam int HI   = 4;
  localparam int LO   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1;
  logic car = 1'b1;
  logic dclk = 1'b0;
  logic data;
  logic dr_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cid_byte_reader #(.BIT_CLKS(BIT), .WORD_BITS(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .rx_bit(rx), .carrier_ok(car),
    .dclk(dclk), .data(data), .dr_n(dr_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int in_rng(input int v, input int lo, input int hi);
    return (v >= lo && v <= hi) ? 1 : 0;
  endfunction

  task automatic send_frame(input logic [7:0] b);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic pulse();
    dclk = 1'b1;
    repeat (HI) @(negedge clk);
    dclk = 1'b0;
    repeat (LO) @(negedge clk);
  endtask

  task automatic read_bits(input int lo, input int hi, inout logic [7:0] got);
    for (int i = lo; i <= hi; i++) begin
      pulse();
      got[i] = data;
    end
  endtask

  // waits for dr_n low; returns cycles waited, -1 on timeout
  task automatic wait_dr(output int t);
    t = 0;
    while (dr_n !== 1'b0 && t < 12 * BIT) begin
      @(negedge clk);
      t++;
    end
    if (dr_n !== 1'b0) t = -1;
  endtask

  // mode 0: timeout then read; 1: read during flag; 2: like 0 plus extra edges
  task automatic word_cycle(input logic [7:0] b, input int mode, input string tag);
    logic [7:0] got;
    int t;
    int lowc;
    got = 8'h00;
    fork
      send_frame(b);
      begin
        wait_dr(t);
        chk({tag, " R3 flag position"}, in_rng(t, 8 * BIT, 9 * BIT), 1);
        if (t >= 0) begin
          if (mode == 1) begin
            pulse();
            got[0] = data;
            chk({tag, " R6 early clear"}, int'(dr_n), 1);
            read_bits(1, 7, got);
          end else begin
            lowc = 0;
            while (dr_n === 1'b0 && lowc < 4 * BIT) begin
              lowc++;
              @(negedge clk);
            end
            chk({tag, " R5 flag width"}, lowc, HALF);
            read_bits(0, 7, got);
            if (mode == 2) begin
              pulse();
              chk({tag, " R7 ninth edge"}, int'(data), int'(b[7]));
              pulse();
              chk({tag, " R7 tenth edge"}, int'(data), int'(b[7]));
            end
          end
        end
      end
    join
    chk({tag, " R2 R4 byte"}, int'(got), int'(b));
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int t;
    int lowc;
    void'($urandom(32'h1bad5eed));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dr_n after reset", int'(dr_n), 1);
    chk("R1 data after reset", int'(data), 1);

    word_cycle(8'hA5, 2, "dir A5");
    word_cycle(8'h3C, 1, "dir 3C");
    word_cycle(8'h00, 0, "dir 00");
    word_cycle(8'hFF, 1, "dir FF");
    word_cycle(8'h80, 2, "dir 80");

    // R9: partial read, then a new word restarts at bit 0
    got = 8'h00;
    fork
      send_frame(8'h96);
      begin
        wait_dr(t);
        read_bits(0, 2, got);
      end
    join
    chk("R9 partial first word", int'(got[2:0]), int'(3'b110));
    word_cycle(8'h5A, 0, "R9 overwrite");

    // R8: carrier loss keeps the half-read buffer and raises no flag
    got = 8'h00;
    fork
      send_frame(8'hC3);
      begin
        wait_dr(t);
        read_bits(0, 3, got);
      end
    join
    repeat (5) @(negedge clk);
    car = 1'b0;
    lowc = 0;
    fork
      send_frame(8'h3E);
      for (int i = 0; i < 11 * BIT; i++) begin
        @(negedge clk);
        if (dr_n !== 1'b1) lowc++;
      end
    join
    chk("R8 no flag without carrier", lowc, 0);
    car = 1'b1;
    repeat (5) @(negedge clk);
    read_bits(4, 7, got);
    chk("R8 buffer kept", int'(got), int'(8'hC3));

    // R10: short low glitch is not a start bit
    rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    lowc = 0;
    for (int i = 0; i < 12 * BIT; i++) begin
      @(negedge clk);
      if (dr_n !== 1'b1) lowc++;
    end
    chk("R10 glitch rejected", lowc, 0);
    word_cycle(8'h81, 0, "R10 recover");

    for (int k = 0; k < 16; k++) begin
      word_cycle(8'($urandom), int'($urandom % 3), "rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule